// File: doc/BRIEF.md
# Supply-Dip Reset Sequencer

This block turns a clocked "supply is below threshold" flag into a registered device reset. A continuous low period must last a set number of cycles before it counts. Reset then stays on for as long as the supply stays low. An optional power-up delay can keep reset on for a fixed number of cycles after the supply is good again. A supply dip during that delay sends the block back into reset, and the delay starts over from zero.

Detection is selected by a two-bit mode:

| Code | Mode |
|------|------|
| 0 | Off |
| 1 | Gated by a software enable bit |
| 2 | Active except while the system sleeps |
| 3 | Always active |

The block also keeps two status flags that software can read, one for power-on events and one for brown-out events. It takes its comparator flag and configuration from the surrounding logic. All durations are parameters counted in clock cycles: `QUAL_CYCLES` for the low-period qualifier and `PWRUP_CYCLES` for the power-up delay.

Top module: `bor_seq_ctrl`

## Requirements
- R1: In mode 0, no supply-low pattern of any length asserts `rst_out`.
- R2: In mode 3, detection is active whether or not `sleep_mode` is set.
- R3: While detection is active and the block is running, `rst_out` rises at the clock edge that samples the `QUAL_CYCLES`-th consecutive high value of `supply_low`. A shorter run does not assert reset. Any cycle with `supply_low` low, or with detection off, restarts the count.
- R4: Once a brown-out has asserted `rst_out`, it stays high for every cycle in which `supply_low` is still high.
- R5: With `pwrt_en` low, `rst_out` falls at the first clock edge that samples `supply_low` low after a brown-out. Turning detection on never enables the delay.
- R6: With `pwrt_en` high, `rst_out` falls at the (`PWRUP_CYCLES`+1)-th edge, counting the first edge that samples the supply as good. If `supply_low` is seen high during the delay while detection is active, the block goes straight back into brown-out and the delay restarts from zero.
- R7: In mode 1, detection follows a stored software enable that is 1 after power-on. Writes through `swen_wr`/`swen_wdata` change it only in mode 1 and are ignored in other modes. `swen_rd` shows the stored bit in mode 1 and reads 0 in every other mode.
- R8: In mode 2, detection is off while `sleep_mode` is 1 and comes back on by itself when `sleep_mode` returns to 0. The qualifier count starts from zero at that point.
- R9: `bor_flag` is 0 after power-on and is cleared on every brown-out entry. A `bor_flag_set` pulse sets it to 1. If a set and a brown-out entry fall in the same cycle, the clear wins.
- R10: `por_flag` is 0 after power-on and becomes 1 only through a `por_flag_set` pulse. A brown-out leaves it unchanged.
- R11: While `por_n` is low, `rst_out` is 1. After release, `rst_out` falls at the first edge if `pwrt_en` is low, or at the `PWRUP_CYCLES`-th edge if `pwrt_en` is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low, asynchronous |
| supply_low | input | 1 | Synchronous supply-below-threshold flag |
| en_mode | input | 2 | Detection mode: 0 off, 1 software, 2 off in sleep, 3 always on |
| sleep_mode | input | 1 | System is in sleep |
| pwrt_en | input | 1 | Enables the power-up delay |
| swen_wr | input | 1 | Write strobe for the software enable |
| swen_wdata | input | 1 | Value written to the software enable |
| por_flag_set | input | 1 | Software pulse that sets the power-on flag |
| bor_flag_set | input | 1 | Software pulse that sets the brown-out flag |
| rst_out | output | 1 | Registered device reset, active high |
| swen_rd | output | 1 | Software enable readback (0 outside mode 1) |
| por_flag | output | 1 | Power-on status flag |
| bor_flag | output | 1 | Brown-out status flag |

## Verification
The following rules are checked by assertions on every cycle:

- reset holds while the supply stays low;
- reset releases at once when the delay is off;
- a dip during the delay clears the delay count;
- sleep masks detection in mode 2;
- mode 0 stays quiet;
- the flags clear and set only in the ways R9 and R10 allow;
- the software enable does not change outside mode 1.

Some properties need whole scenarios to show:

- the exact cycle on which reset rises or falls;
- qualifier dips one cycle short of the limit;
- a re-armed delay that runs its full length again;
- a write ignored in one mode and then read back in another.

The bench's reference model and directed checks cover these.

// File: rtl/bor_pkg.sv
package bor_pkg;

  typedef enum logic [1:0] {
    PH_RUN   = 2'd0,
    PH_BROWN = 2'd1,
    PH_PWRUP = 2'd2
  } bor_phase_e;

  localparam logic [1:0] MODE_OFF     = 2'd0;
  localparam logic [1:0] MODE_SW      = 2'd1;
  localparam logic [1:0] MODE_NOSLEEP = 2'd2;
  localparam logic [1:0] MODE_ON      = 2'd3;

  // Detection is active for a given mode, software enable and sleep state
  function automatic logic detect_on(input logic [1:0] mode, input logic sw_en,
                                     input logic sleeping);
    case (mode)
      MODE_SW:      return sw_en;
      MODE_NOSLEEP: return !sleeping;
      MODE_ON:      return 1'b1;
      default:      return 1'b0;
    endcase
  endfunction

  // Counter width needed to reach n
  function automatic int cnt_width(input int n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/bor_qual.sv
module bor_qual #(
  parameter int QUAL_CYCLES = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic sample_en,
  output logic hit
);
  import bor_pkg::*;
  localparam int QW = cnt_width(QUAL_CYCLES);
  localparam logic [QW-1:0] LAST = QW'(QUAL_CYCLES - 1);
  localparam logic [QW-1:0] TOP  = QW'(QUAL_CYCLES);

  logic [QW-1:0] q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)          q <= '0;
    else if (!sample_en) q <= '0;
    else if (q != TOP)   q <= q + 1'b1;
  end

  assign hit = sample_en && (q == LAST);

  generate
    if (QUAL_CYCLES > 1) begin : g_chk
      AST_HIT_NEEDS_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        hit |-> $past(sample_en)); // R3
    end
  endgenerate
endmodule

// File: rtl/bor_pwrup_tmr.sv
module bor_pwrup_tmr #(
  parameter int PWRUP_CYCLES = 6
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run_en,
  output logic done,
  output logic idle
);
  import bor_pkg::*;
  localparam int CW = cnt_width(PWRUP_CYCLES);
  localparam logic [CW-1:0] LAST = CW'(PWRUP_CYCLES - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt <= '0;
    else if (!run_en) cnt <= '0;
    else if (!done)   cnt <= cnt + 1'b1;
  end

  assign done = run_en && (cnt == LAST);
  assign idle = (cnt == '0);

  generate
    if (PWRUP_CYCLES > 1) begin : g_chk
      AST_DONE_AFTER_RUN: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(run_en)); // R6
    end
  endgenerate
endmodule

// File: rtl/bor_status.sv
module bor_status (
  input  logic       clk,
  input  logic       rst_n,
  input  logic [1:0] en_mode,
  input  logic       swen_wr,
  input  logic       swen_wdata,
  input  logic       por_set,
  input  logic       bor_set,
  input  logic       bor_evt,
  output logic       sw_en,
  output logic       swen_rd,
  output logic       por_flag,
  output logic       bor_flag
);
  import bor_pkg::*;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sw_en    <= 1'b1;
      por_flag <= 1'b0;
      bor_flag <= 1'b0;
    end else begin
      if (swen_wr && en_mode == MODE_SW) sw_en <= swen_wdata;
      if (por_set) por_flag <= 1'b1;
      if (bor_evt)      bor_flag <= 1'b0;
      else if (bor_set) bor_flag <= 1'b1;
    end
  end

  assign swen_rd = (en_mode == MODE_SW) && sw_en;

  AST_BOR_CLEARED: assert property (@(posedge clk) disable iff (!rst_n)
    bor_evt |=> !bor_flag); // R9
  AST_POR_SW_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(por_flag) |-> $past(por_set)); // R10
  AST_SWEN_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    en_mode != MODE_SW |=> sw_en == $past(sw_en)); // R7
endmodule

// File: rtl/bor_seq_ctrl.sv
module bor_seq_ctrl #(
  parameter int QUAL_CYCLES  = 4,
  parameter int PWRUP_CYCLES = 6
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       supply_low,
  input  logic [1:0] en_mode,
  input  logic       sleep_mode,
  input  logic       pwrt_en,
  input  logic       swen_wr,
  input  logic       swen_wdata,
  input  logic       por_flag_set,
  input  logic       bor_flag_set,
  output logic       rst_out,
  output logic       swen_rd,
  output logic       por_flag,
  output logic       bor_flag
);
  import bor_pkg::*;

  bor_phase_e phase, phase_nx;
  logic sw_en, detect, qual_en, qual_hit, tmr_en, tmr_done, tmr_idle;
  logic dip_in_delay, bor_evt, rst_nx;

  assign detect       = detect_on(en_mode, sw_en, sleep_mode);
  assign qual_en      = (phase == PH_RUN) && detect && supply_low;
  assign dip_in_delay = (phase == PH_PWRUP) && detect && supply_low;
  assign tmr_en       = (phase == PH_PWRUP) && pwrt_en && !dip_in_delay;

  bor_qual #(.QUAL_CYCLES(QUAL_CYCLES)) u_qual (
    .clk(clk), .rst_n(por_n), .sample_en(qual_en), .hit(qual_hit)
  );

  bor_pwrup_tmr #(.PWRUP_CYCLES(PWRUP_CYCLES)) u_tmr (
    .clk(clk), .rst_n(por_n), .run_en(tmr_en), .done(tmr_done), .idle(tmr_idle)
  );

  always_comb begin
    phase_nx = phase;
    rst_nx   = rst_out;
    case (phase)
      PH_RUN: if (qual_hit) begin
        phase_nx = PH_BROWN;
        rst_nx   = 1'b1;
      end
      PH_BROWN: if (!supply_low) begin
        phase_nx = pwrt_en ? PH_PWRUP : PH_RUN;
        rst_nx   = pwrt_en;
      end
      PH_PWRUP: begin
        if (dip_in_delay) begin
          phase_nx = PH_BROWN;
          rst_nx   = 1'b1;
        end else if (!pwrt_en || tmr_done) begin
          phase_nx = PH_RUN;
          rst_nx   = 1'b0;
        end
      end
      default: begin
        phase_nx = PH_BROWN;
        rst_nx   = 1'b1;
      end
    endcase
  end

  assign bor_evt = (phase_nx == PH_BROWN) && (phase != PH_BROWN);

  always_ff @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      phase   <= PH_PWRUP;
      rst_out <= 1'b1;
    end else begin
      phase   <= phase_nx;
      rst_out <= rst_nx;
    end
  end

  bor_status u_status (
    .clk(clk), .rst_n(por_n), .en_mode(en_mode),
    .swen_wr(swen_wr), .swen_wdata(swen_wdata),
    .por_set(por_flag_set), .bor_set(bor_flag_set), .bor_evt(bor_evt),
    .sw_en(sw_en), .swen_rd(swen_rd), .por_flag(por_flag), .bor_flag(bor_flag)
  );

  AST_MODE_OFF_QUIET: assert property (@(posedge clk) disable iff (!por_n)
    (en_mode == MODE_OFF && phase == PH_RUN) |=> !rst_out); // R1
  AST_ALWAYS_ON_SLEEP: assert property (@(posedge clk) disable iff (!por_n)
    (en_mode == MODE_ON && sleep_mode && phase == PH_RUN && qual_hit) |=> rst_out); // R2
  AST_HOLD_WHILE_LOW: assert property (@(posedge clk) disable iff (!por_n)
    (phase == PH_BROWN && supply_low) |=> (rst_out && phase == PH_BROWN)); // R4
  AST_FAST_RELEASE: assert property (@(posedge clk) disable iff (!por_n)
    (phase == PH_BROWN && !supply_low && !pwrt_en) |=> !rst_out); // R5
  AST_DIP_REARM: assert property (@(posedge clk) disable iff (!por_n)
    dip_in_delay |=> (phase == PH_BROWN && tmr_idle && rst_out)); // R6
  AST_SLEEP_MASK: assert property (@(posedge clk) disable iff (!por_n)
    (en_mode == MODE_NOSLEEP && sleep_mode && phase == PH_RUN) |=> phase == PH_RUN); // R8
  AST_RUN_NO_RESET: assert property (@(posedge clk) disable iff (!por_n)
    (phase == PH_RUN && !qual_hit) |=> !rst_out); // R3
endmodule

// File: tb/bor_seq_ctrl_bench.sv
module bor_seq_ctrl_bench;
  localparam int QUAL = 4;
  localparam int DLY  = 6;

  logic clk = 1'b0;
  logic por_n = 1'b0, supply_low = 1'b0, sleep_mode = 1'b0, pwrt_en = 1'b0;
  logic [1:0] en_mode = 2'd3;
  logic swen_wr = 1'b0, swen_wdata = 1'b0, por_flag_set = 1'b0, bor_flag_set = 1'b0;
  logic rst_out, swen_rd, por_flag, bor_flag;

  int total = 0, bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  bor_seq_ctrl #(.QUAL_CYCLES(QUAL), .PWRUP_CYCLES(DLY)) u_bor_seq_ctrl (
    .clk(clk), .por_n(por_n), .supply_low(supply_low), .en_mode(en_mode),
    .sleep_mode(sleep_mode), .pwrt_en(pwrt_en), .swen_wr(swen_wr),
    .swen_wdata(swen_wdata), .por_flag_set(por_flag_set),
    .bor_flag_set(bor_flag_set), .rst_out(rst_out), .swen_rd(swen_rd),
    .por_flag(por_flag), .bor_flag(bor_flag)
  );

  // Behavioural reference: state 0 running, 1 in brown-out, 2 delaying
  int  m_state, m_lowrun, m_wait;
  bit  m_rst, m_bor, m_por, m_sw, m_det;

  always @(posedge clk or negedge por_n) begin
    if (!por_n) begin
      m_state = 2; m_lowrun = 0; m_wait = 0;
      m_rst = 1; m_bor = 0; m_por = 0; m_sw = 1;
    end else begin
      m_det = (en_mode == 2'd3) || (en_mode == 2'd2 && !sleep_mode) ||
              (en_mode == 2'd1 && m_sw);
      if (bor_flag_set) m_bor = 1;
      if (por_flag_set) m_por = 1;
      if (m_state == 0) begin
        if (m_det && supply_low) begin
          m_lowrun++;
          if (m_lowrun >= QUAL) begin m_state = 1; m_rst = 1; m_bor = 0; m_lowrun = 0; end
        end else m_lowrun = 0;
      end else if (m_state == 1) begin
        if (!supply_low) begin
          if (pwrt_en) begin m_state = 2; m_wait = 0; end
          else begin m_state = 0; m_rst = 0; end
        end
      end else begin
        if (m_det && supply_low) begin m_state = 1; m_bor = 0; m_wait = 0; end
        else if (!pwrt_en) begin m_state = 0; m_rst = 0; m_wait = 0; end
        else begin
          m_wait++;
          if (m_wait >= DLY) begin m_state = 0; m_rst = 0; m_wait = 0; end
        end
      end
      if (swen_wr && en_mode == 2'd1) m_sw = swen_wdata;
    end
  end

  task automatic check(input string req, input logic act, input logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%0b expected=%0b at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model
  always @(negedge clk) begin
    if (por_n && !finished) begin
      check("R3 model rst_out", rst_out, m_rst);
      check("R7 model swen_rd", swen_rd, (en_mode == 2'd1) && m_sw);
      check("R9 model bor_flag", bor_flag, m_bor);
      check("R10 model por_flag", por_flag, m_por);
    end
  end

  task automatic step(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic do_por(input logic with_delay);
    por_n = 1'b0; pwrt_en = with_delay;
    step(2);
    check("R11 rst during por", rst_out, 1'b1);
    check("R10 por_flag after por", por_flag, 1'b0);
    check("R9 bor_flag after por", bor_flag, 1'b0);
    por_n = 1'b1;
  endtask

  task automatic pulse_bor_set();
    bor_flag_set = 1'b1; step(1); bor_flag_set = 1'b0;
  endtask

  task automatic write_sw(input logic v);
    swen_wr = 1'b1; swen_wdata = v; step(1); swen_wr = 1'b0;
  endtask

  // Drive a low run of n cycles, then restore a good supply
  task automatic dip(input int n);
    supply_low = 1'b1; step(n); supply_low = 1'b0;
  endtask

  initial begin
    en_mode = 2'd3;
    do_por(1'b0);
    step(1);
    check("R11 release without delay", rst_out, 1'b0);
    check("R7 swen_rd in mode 3", swen_rd, 1'b0);

    do_por(1'b1);
    step(DLY - 1);
    check("R11 held during delay", rst_out, 1'b1);
    step(1);
    check("R11 release after delay", rst_out, 1'b0);
    pwrt_en = 1'b0;

    // R3: short dips ignored, exact trip cycle
    dip(QUAL - 1); step(1);
    check("R3 short dip ignored", rst_out, 1'b0);
    dip(QUAL - 1); step(1); dip(QUAL - 1); step(1);
    check("R3 broken runs ignored", rst_out, 1'b0);
    pulse_bor_set();
    check("R9 flag set by software", bor_flag, 1'b1);
    supply_low = 1'b1; step(QUAL - 1);
    check("R3 one cycle short", rst_out, 1'b0);
    step(1);
    check("R3 trip at limit", rst_out, 1'b1);
    check("R9 flag cleared on brown-out", bor_flag, 1'b0);
    step(10);
    check("R4 held while low", rst_out, 1'b1);
    supply_low = 1'b0; step(1);
    check("R5 immediate release", rst_out, 1'b0);

    // R6: delay with a dip that re-arms it
    pwrt_en = 1'b1;
    dip(QUAL);
    check("R6 tripped", rst_out, 1'b1);
    step(3);
    check("R6 counting", rst_out, 1'b1);
    dip(1);
    check("R6 dip returns to reset", rst_out, 1'b1);
    step(DLY);
    check("R6 restarted delay still held", rst_out, 1'b1);
    step(1);
    check("R6 release after full delay", rst_out, 1'b0);
    pwrt_en = 1'b0;

    // R1: mode 0
    en_mode = 2'd0;
    dip(20); step(1);
    check("R1 mode 0 no reset", rst_out, 1'b0);

    // R7: software gating
    en_mode = 2'd1; step(1);
    check("R7 enable is 1 after por", swen_rd, 1'b1);
    dip(QUAL);
    check("R7 trip when enabled", rst_out, 1'b1);
    step(1);
    write_sw(1'b0);
    check("R7 readback after clear", swen_rd, 1'b0);
    dip(20); step(1);
    check("R7 disabled no trip", rst_out, 1'b0);
    en_mode = 2'd3; write_sw(1'b1);
    en_mode = 2'd1; step(1);
    check("R7 write ignored in mode 3", swen_rd, 1'b0);
    write_sw(1'b1);
    check("R7 write in mode 1", swen_rd, 1'b1);

    // R8: sleep masks mode 2
    en_mode = 2'd2; sleep_mode = 1'b1;
    supply_low = 1'b1; step(20);
    check("R8 masked in sleep", rst_out, 1'b0);
    sleep_mode = 1'b0; step(QUAL - 1);
    check("R8 count restarts on wake", rst_out, 1'b0);
    step(1);
    check("R8 re-enabled on wake", rst_out, 1'b1);
    supply_low = 1'b0; step(1);

    // R2: mode 3 ignores sleep
    en_mode = 2'd3; sleep_mode = 1'b1;
    dip(QUAL);
    check("R2 active in sleep", rst_out, 1'b1);
    step(1); sleep_mode = 1'b0;

    // R9 clear wins over set; R10 flag survives brown-out
    por_flag_set = 1'b1; step(1); por_flag_set = 1'b0;
    check("R10 set by software", por_flag, 1'b1);
    supply_low = 1'b1; step(QUAL - 1);
    bor_flag_set = 1'b1; step(1); bor_flag_set = 1'b0;
    check("R9 clear wins", bor_flag, 1'b0);
    check("R10 kept over brown-out", por_flag, 1'b1);
    supply_low = 1'b0; step(1);
    do_por(1'b0);
    step(2);

    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      total++; bad++;
      $display("FAIL watchdog R11 actual=hung expected=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule